// File: doc/BRIEF.md
# Packet Snippet Report Serializer

This block sits beside a repeater's receive path and produces one serial report per received packet. A report is the opening bits of the packet, copied bit for bit up to a programmable length, followed by a fixed-width status word that the surrounding logic presents when the frame closes. The report goes out on a single data line, one bit per clock, with a clock-enable that marks each valid report bit.

Several devices can share the report channel. The block asserts an active-low busy output while it owns the channel and an active-low drive output while its data line carries report content. It watches an active-low busy input from the other devices and starts a report only when the channel is free at the start of a packet. A collision during the copy phase aborts the report. A packet that starts while a status word is still being shifted out is not reported. The busy output stays asserted until that packet has ended, but the drive output is released as soon as the last status bit is out.

Top module: `snippet_reporter`

## Requirements
- R1: After reset, rpt_data and rpt_ck_en are 0 and drive_n and busy_out_n are 1.
- R2: When a report starts, each packet bit sampled with rx_frame high appears on rpt_data one clock later, with rpt_ck_en high, until snip_len bits have been copied.
- R3: snip_len is sampled in the first cycle of the frame. A packet shorter than snip_len ends its snippet at the frame end, and the status follows with no gap.
- R4: stat_word is sampled in the first cycle with rx_frame low. Its 16 bits follow MSB first on consecutive clocks with rpt_ck_en high. Between the last snippet bit and the frame end, drive_n stays 0 while rpt_ck_en and rpt_data are 0.
- R5: With snip_len equal to 0, the report consists of the status word only, and drive_n is held low from the frame start onward.
- R6: If busy_in_n is 0 in the first cycle of a frame, that packet produces no report bits and drive_n and busy_out_n stay 1, even if busy_in_n is released before the frame ends.
- R7: An rx_col high while the snippet is being copied, or while the block waits for the frame end, raises drive_n and busy_out_n on the next clock. No further report bits are sent for that packet.
- R8: A frame that starts before the last status bit has been sent is not reported. drive_n rises on the clock after the last status bit, and busy_out_n stays 0 until the clock on which that frame ends.
- R9: drive_n low always implies busy_out_n low. While drive_n is high, rpt_data and rpt_ck_en are 0.
- R10: After an aborted, skipped or dropped packet, the next packet that meets the start conditions is reported in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock for receive and report |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_frame | input | 1 | High while the received frame carries valid bits |
| rx_bit | input | 1 | Received serial data bit |
| rx_col | input | 1 | Collision indication |
| snip_len | input | LEN_W (8) | Number of leading packet bits to report |
| stat_word | input | STAT_W (16) | Status word, valid in the first cycle after the frame |
| busy_in_n | input | 1 | Active-low: another device is using the report channel |
| rpt_data | output | 1 | Report data bit |
| rpt_ck_en | output | 1 | High when rpt_data carries a report bit |
| busy_out_n | output | 1 | Active-low: this device owns the report channel |
| drive_n | output | 1 | Active-low output enable for the report data line |

## Verification
The hardest case to reach is a second frame arriving during the narrow window in which the previous packet's status word is still being shifted. The bench hits it by stepping the inputs cycle by cycle from a single counter. It places the second frame start a few clocks into the status phase and holds that frame open well past the last status bit. This separates the early release of drive_n from the later release of busy_out_n. The collision abort is produced the same way, with rx_col raised mid-snippet. The busy input is released partway through a frame, which shows that the skip decision is taken only once, at the frame start.

// File: rtl/snippet_reporter_pkg.sv
package snippet_reporter_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,  // channel released, waiting for a frame start
        ST_SNIP,  // copying leading packet bits
        ST_WAIT,  // snippet complete, waiting for frame end
        ST_STAT,  // shifting status word
        ST_HOLD,  // status done, dropped frame still running
        ST_SKIP   // ignoring the rest of this frame
    } rpt_state_e;

endpackage

// File: rtl/sr_frame_edge.sv
module sr_frame_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic frame,
    output logic sof,
    output logic eof
);
    logic frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frame_q <= 1'b0;
        else        frame_q <= frame;
    end

    assign sof = frame & ~frame_q;
    assign eof = ~frame & frame_q;
endmodule

// File: rtl/sr_counter.sv
module sr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (clr ? '0 : cnt_q) + (inc ? W'(1) : W'(0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R2: the copy and status counters never wrap around
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (cnt_q != '1));
endmodule

// File: rtl/snippet_reporter.sv
module snippet_reporter
    import snippet_reporter_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_frame,
    input  logic              rx_bit,
    input  logic              rx_col,
    input  logic [LEN_W-1:0]  snip_len,
    input  logic [STAT_W-1:0] stat_word,
    input  logic              busy_in_n,
    output logic              rpt_data,
    output logic              rpt_ck_en,
    output logic              busy_out_n,
    output logic              drive_n
);
    localparam int SCW = $clog2(STAT_W + 1);

    typedef struct packed {
        rpt_state_e        st;
        logic [LEN_W-1:0]  len;
        logic [STAT_W-1:0] sh;
        logic              data;
        logic              ck;
        logic              drv;
        logic              bsy;
    } rpt_reg_t;

    rpt_reg_t r_d, r_q;

    logic             sof, eof;
    logic             sn_clr, sn_inc, st_clr, st_inc;
    logic [LEN_W-1:0] sn_cnt;
    logic [SCW-1:0]   st_cnt;

    sr_frame_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .frame (rx_frame),
        .sof   (sof),
        .eof   (eof)
    );

    sr_counter #(.W(LEN_W)) u_snip_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sn_clr),
        .inc   (sn_inc),
        .cnt   (sn_cnt)
    );

    sr_counter #(.W(SCW)) u_stat_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_clr),
        .inc   (st_inc),
        .cnt   (st_cnt)
    );

    always_comb begin
        r_d    = r_q;
        r_d.data = 1'b0;
        r_d.ck   = 1'b0;
        r_d.drv  = 1'b0;
        r_d.bsy  = 1'b0;
        sn_clr = 1'b0;
        sn_inc = 1'b0;
        st_clr = 1'b0;
        st_inc = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (sof) begin
                    if (!busy_in_n || rx_col) begin
                        r_d.st = ST_SKIP;
                    end else begin
                        r_d.len = snip_len;
                        r_d.drv = 1'b1;
                        r_d.bsy = 1'b1;
                        if (snip_len == '0) begin
                            r_d.st = ST_WAIT;
                        end else begin
                            r_d.data = rx_bit;
                            r_d.ck   = 1'b1;
                            sn_clr   = 1'b1;
                            sn_inc   = 1'b1;
                            r_d.st   = (snip_len == LEN_W'(1)) ? ST_WAIT : ST_SNIP;
                        end
                    end
                end
            end

            ST_SNIP, ST_WAIT: begin
                if (rx_col) begin
                    r_d.st = rx_frame ? ST_SKIP : ST_IDLE;
                end else if (eof) begin
                    r_d.data = stat_word[STAT_W-1];
                    r_d.ck   = 1'b1;
                    r_d.drv  = 1'b1;
                    r_d.bsy  = 1'b1;
                    r_d.sh   = stat_word << 1;
                    st_clr   = 1'b1;
                    st_inc   = 1'b1;
                    r_d.st   = ST_STAT;
                end else begin
                    r_d.drv = 1'b1;
                    r_d.bsy = 1'b1;
                    if (r_q.st == ST_SNIP) begin
                        r_d.data = rx_bit;
                        r_d.ck   = 1'b1;
                        sn_inc   = 1'b1;
                        if ((sn_cnt + LEN_W'(1)) == r_q.len) r_d.st = ST_WAIT;
                    end
                end
            end

            ST_STAT: begin
                r_d.data = r_q.sh[STAT_W-1];
                r_d.ck   = 1'b1;
                r_d.drv  = 1'b1;
                r_d.bsy  = 1'b1;
                r_d.sh   = r_q.sh << 1;
                st_inc   = 1'b1;
                if (st_cnt == SCW'(STAT_W - 1)) begin
                    r_d.st = rx_frame ? ST_HOLD : ST_IDLE;
                end
            end

            ST_HOLD: begin
                if (rx_frame) r_d.bsy = 1'b1;
                else          r_d.st  = ST_IDLE;
            end

            ST_SKIP: begin
                if (!rx_frame) r_d.st = ST_IDLE;
            end

            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rpt_data   = r_q.data;
    assign rpt_ck_en  = r_q.ck;
    assign drive_n    = ~r_q.drv;
    assign busy_out_n = ~r_q.bsy;

    // R9: the data line is driven only while the channel is owned
    p_drive_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_n |-> !busy_out_n);

    // R9: an undriven line is quiet
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drive_n |-> (!rpt_data && !rpt_ck_en));

    // R7: a collision while copying or waiting releases the channel
    p_col_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_col && (r_q.st == ST_SNIP || r_q.st == ST_WAIT)) |=> (drive_n && busy_out_n));

    // R6: a frame that starts while the channel is busy is not reported
    p_skip_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && sof && !busy_in_n) |=> (drive_n && busy_out_n));

    // R8: a frame open at the last status bit keeps the channel owned
    p_drop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STAT && st_cnt == SCW'(STAT_W - 1) && rx_frame) |=> (!busy_out_n && !drive_n));

    // R4: the status counter stays within the word length
    p_stat_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_cnt <= SCW'(STAT_W));
endmodule

// File: tb/snippet_reporter_test.sv
module snippet_reporter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_frame = 1'b0;
    logic        rx_bit = 1'b0;
    logic        rx_col = 1'b0;
    logic [7:0]  snip_len = 8'd0;
    logic [15:0] stat_word = 16'd0;
    logic        busy_in_n = 1'b1;
    logic        rpt_data, rpt_ck_en, busy_out_n, drive_n;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    snippet_reporter uut (
        .clk(clk), .rst_n(rst_n), .rx_frame(rx_frame), .rx_bit(rx_bit),
        .rx_col(rx_col), .snip_len(snip_len), .stat_word(stat_word),
        .busy_in_n(busy_in_n), .rpt_data(rpt_data), .rpt_ck_en(rpt_ck_en),
        .busy_out_n(busy_out_n), .drive_n(drive_n)
    );

    // monitor: sole owner of the capture record
    logic cap [0:1023];
    int ncap = 0;
    int ngap = 0;
    int nbad = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rpt_ck_en && ncap < 1024) begin
                cap[ncap] = rpt_data;
                ncap++;
            end
            if (!drive_n && !rpt_ck_en) ngap++;
            if (drive_n && (rpt_data || rpt_ck_en)) nbad++;
            if (!drive_n && busy_out_n) nbad++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // {len, snip, channel free, pattern, status}
    localparam logic [71:0] VEC [0:5] = '{
        {8'd20, 8'd8,  8'd1, 32'hA5C30F1E, 16'hBEEF},
        {8'd5,  8'd12, 8'd1, 32'h00000015, 16'h1234},
        {8'd10, 8'd0,  8'd1, 32'h000002AA, 16'h8001},
        {8'd10, 8'd10, 8'd1, 32'h000003FF, 16'h0F0F},
        {8'd12, 8'd6,  8'd0, 32'h00000FFF, 16'hFFFF},
        {8'd30, 8'd1,  8'd1, 32'h3C3C3C3D, 16'hA5A5}
    };

    task automatic send_pkt(input int len, input logic [31:0] pat,
                            input logic [15:0] st, input int bsy_cycles);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_frame  = 1'b1;
            rx_bit    = pat[i % 32];
            busy_in_n = (i < bsy_cycles) ? 1'b0 : 1'b1;
        end
        @(negedge clk);
        rx_frame  = 1'b0;
        rx_bit    = 1'b0;
        stat_word = st;
        busy_in_n = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic run_vec(input int k, input string req);
        int len, snip, nexp, b0, g0, x0, mism, ncopy;
        logic free;
        logic [31:0] pat;
        logic [15:0] st;
        len  = int'(VEC[k][71:64]);
        snip = int'(VEC[k][63:56]);
        free = VEC[k][48];
        pat  = VEC[k][47:16];
        st   = VEC[k][15:0];
        snip_len = 8'(snip);
        b0 = ncap; g0 = ngap; x0 = nbad;
        send_pkt(len, pat, st, free ? 0 : 3);
        ncopy = (snip < len) ? snip : len;
        nexp  = free ? ncopy + 16 : 0;
        chk(ncap - b0 == nexp, req, "report bit count", ncap - b0, nexp);
        mism = 0;
        for (int j = 0; j < nexp && j < ncap - b0; j++) begin
            logic e;
            e = (j < ncopy) ? pat[j] : st[15 - (j - ncopy)];
            if (cap[b0 + j] !== e) mism++;
        end
        chk(mism == 0, req, "report bit mismatches", mism, 0);
        chk(ngap - g0 == (free ? len - ncopy : 0), "R4", "undriven-data gap cycles",
            ngap - g0, free ? len - ncopy : 0);
        chk(nbad == x0, "R9", "quiet/ownership violations", nbad - x0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(rpt_data == 0 && rpt_ck_en == 0, "R1", "data/ck after reset",
            int'({rpt_data, rpt_ck_en}), 0);
        chk(drive_n && busy_out_n, "R1", "drive_n/busy_out_n after reset",
            int'({drive_n, busy_out_n}), 3);

        // table: R2 normal, R3 short packet, R5 zero length, R6 busy channel
        run_vec(0, "R2");
        run_vec(1, "R3");
        run_vec(2, "R5");
        run_vec(3, "R2");
        run_vec(4, "R6");
        run_vec(5, "R10");

        // R2 latency and R7 collision abort, stepped per cycle
        snip_len = 8'd16;
        b0 = ncap;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 1) chk(rpt_data == 1 && rpt_ck_en == 1 && !drive_n, "R2",
                            "first bit one clock after frame start",
                            int'({rpt_data, rpt_ck_en, drive_n}), 6);
            if (i == 5) chk(drive_n && busy_out_n, "R7", "release after collision",
                            int'({drive_n, busy_out_n}), 3);
            rx_frame = (i < 12);
            rx_bit   = (i < 12) ? ~i[0] : 1'b0;
            rx_col   = (i == 4);
        end
        chk(ncap - b0 == 4, "R7", "bits before abort", ncap - b0, 4);

        // R8: second frame during status
        snip_len = 8'd8;
        b0 = ncap;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i == 20) chk(!drive_n, "R8", "drive_n low during last status bit",
                             int'(drive_n), 0);
            if (i == 21) chk(drive_n && !busy_out_n, "R8", "drive released, busy held",
                             int'({drive_n, busy_out_n}), 2);
            if (i == 39) chk(!busy_out_n, "R8", "busy held through dropped frame",
                             int'(busy_out_n), 0);
            if (i == 41) chk(busy_out_n, "R8", "busy released after dropped frame",
                             int'(busy_out_n), 1);
            rx_frame  = (i < 4) || (i >= 9 && i < 39);
            rx_bit    = (i < 4) ? 1'b1 : i[1];
            stat_word = 16'hC3A5;
        end
        chk(ncap - b0 == 20, "R8", "only first packet reported", ncap - b0, 20);

        // R10: normal report after the drop
        run_vec(0, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule